// File: doc/BRIEF.md
# Host-to-Sound Shared RAM Bridge

This block sits between a 32-bit host bus and the 16-bit work RAM of a sound processor. Each host word maps onto a pair of adjacent 16-bit RAM locations. Inside each half-word the two bytes are exchanged on the way in and again on the way out, so the host and the sound processor each see the data in their own byte order. Byte enables follow the same exchange, so a partial host write changes only the bytes it names.

The RAM is a behavioural array held inside the block. It is split into an even bank and an odd bank, so that a whole host word is stored in one cycle. A read-only sound-side port returns any 16-bit location, which exposes the exact storage layout.

A separate control write starts or stops the sound processor. Two mirror-image 16-bit codes, carried in the upper half of the control word, release or assert a pair of halt and reset outputs. After system reset the processor is held stopped. The parameter `HOST_AW` sets the host window; a value of 19 gives the full 2 MB array (0x80000 host words).

Top module: `snd_ram_bridge`

## Requirements
- R1: A host write to word offset N stores the upper host half-word (bits 31:16) at 16-bit RAM location 2N and the lower half-word (bits 15:0) at location 2N+1.
- R2: Stored halves are byte-exchanged. Location 2N holds host bits 23:16 in its bits 15:8 and host bits 31:24 in its bits 7:0. Location 2N+1 holds host bits 7:0 in its bits 15:8 and host bits 15:8 in its bits 7:0.
- R3: Host byte enable k (k = 0..3) governs host bits 8k+7:8k, wherever that byte lands under R2. RAM bytes whose enable is clear keep their previous contents.
- R4: A host read strobe at offset N loads `host_rdata` on the next clock edge. The upper half is the byte-exchanged location 2N and the lower half is the byte-exchanged location 2N+1, so a full write reads back unchanged.
- R5: When `host_rd` is low, `host_rdata` keeps its value, even across host writes and address changes.
- R6: `snd_rdata` presents the 16-bit RAM location addressed by `snd_addr` one clock after that address is applied.
- R7: A control write with at least one of `ctl_be[3:2]` set and `ctl_wdata[31:16]` = 0x55AA deasserts `snd_halt` and `snd_reset` on the next clock edge.
- R8: A control write with at least one of `ctl_be[3:2]` set and `ctl_wdata[31:16]` = 0xAA55 asserts `snd_halt` and `snd_reset` on the next clock edge.
- R9: A control write with any other upper value, or with both `ctl_be[3:2]` clear, leaves `snd_halt` and `snd_reset` unchanged.
- R10: During and after synchronous reset, `snd_halt` and `snd_reset` are 1 and `host_rdata` is 0 until the first read.
- R11: `snd_halt` and `snd_reset` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | HOST_AW | Host word offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte enables, bit k for bits 8k+7:8k |
| host_rdata | output | 32 | Registered host read data |
| snd_addr | input | HOST_AW+1 | Sound-side 16-bit location address |
| snd_rdata | output | 16 | Registered sound-side read data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write data |
| ctl_be | input | 4 | Control byte enables |
| snd_halt | output | 1 | Halt request to the sound processor |
| snd_reset | output | 1 | Reset request to the sound processor |

## Verification
The bench builds the bridge with `HOST_AW` = 4, which gives 16 host words over 32 RAM locations. At that size both the lowest and the highest host offsets can be written and inspected from the sound side in a few cycles. The small window also lets the bench check the pairing of location 2N with 2N+1 at the top address, where a carry error in the bank select would show. The run-control codes do not depend on the parameter, so the bench covers each accepted and rejected control write at this one size.

// File: rtl/snd_bridge_pkg.sv
package snd_bridge_pkg;
  localparam int HALF_W = 16;
  localparam logic [HALF_W-1:0] RUN_CODE  = 16'h55AA;
  localparam logic [HALF_W-1:0] STOP_CODE = 16'hAA55;

  function automatic logic [HALF_W-1:0] swap_bytes(input logic [HALF_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [1:0] swap_en(input logic [1:0] e);
    return {e[0], e[1]};
  endfunction
endpackage

// File: rtl/sbr_lane_split.sv
module sbr_lane_split
  import snd_bridge_pkg::*;
(
  input  logic [31:0]       host_wdata,
  input  logic [3:0]        host_be,
  output logic [HALF_W-1:0] even_wdata,
  output logic [1:0]        even_be,
  output logic [HALF_W-1:0] odd_wdata,
  output logic [1:0]        odd_be,
  input  logic [HALF_W-1:0] even_rdata,
  input  logic [HALF_W-1:0] odd_rdata,
  output logic [31:0]       host_word
);
  always_comb begin
    even_wdata = swap_bytes(host_wdata[31:16]);
    even_be    = swap_en(host_be[3:2]);
    odd_wdata  = swap_bytes(host_wdata[15:0]);
    odd_be     = swap_en(host_be[1:0]);
    host_word  = {swap_bytes(even_rdata), swap_bytes(odd_rdata)};
  end
endmodule

// File: rtl/sbr_ram_bank.sv
module sbr_ram_bank #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    be,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic          host_en,
  input  logic [AW-1:0] host_raddr,
  output logic [15:0]   host_q,
  input  logic [AW-1:0] snd_raddr,
  output logic [15:0]   snd_q
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] host_byte;
    logic [7:0] snd_byte;

    always_ff @(posedge clk) begin
      if (we && be[l])
        lane_mem[waddr] <= wdata[8*l +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst)
        host_byte <= 8'h00;
      else if (host_en)
        host_byte <= lane_mem[host_raddr];
    end

    always_ff @(posedge clk) begin
      snd_byte <= lane_mem[snd_raddr];
    end

    assign host_q[8*l +: 8] = host_byte;
    assign snd_q[8*l +: 8]  = snd_byte;
  end
endmodule

// File: rtl/sbr_run_ctrl.sv
module sbr_run_ctrl
  import snd_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic [3:0]  ctl_be,
  output logic        halt_q,
  output logic        reset_q
);
  logic upper_hit;
  logic go_run;
  logic go_stop;

  always_comb begin
    upper_hit = ctl_wr && (ctl_be[3:2] != 2'b00);
    go_run    = upper_hit && (ctl_wdata[31:16] == RUN_CODE);
    go_stop   = upper_hit && (ctl_wdata[31:16] == STOP_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b1;
      reset_q <= 1'b1;
    end else if (go_run) begin
      halt_q  <= 1'b0;
      reset_q <= 1'b0;
    end else if (go_stop) begin
      halt_q  <= 1'b1;
      reset_q <= 1'b1;
    end
  end
endmodule

// File: rtl/snd_ram_bridge.sv
module snd_ram_bridge
  import snd_bridge_pkg::*;
#(
  parameter int HOST_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [31:0]        host_wdata,
  input  logic [3:0]         host_be,
  output logic [31:0]        host_rdata,
  input  logic [HOST_AW:0]   snd_addr,
  output logic [15:0]        snd_rdata,
  input  logic               ctl_wr,
  input  logic [31:0]        ctl_wdata,
  input  logic [3:0]         ctl_be,
  output logic               snd_halt,
  output logic               snd_reset
);
  localparam int SND_AW = HOST_AW + 1;

  logic [HALF_W-1:0] even_wdata, odd_wdata;
  logic [1:0]        even_be, odd_be;
  logic [HALF_W-1:0] even_hq, odd_hq, even_sq, odd_sq;
  logic              snd_sel_q;

  sbr_lane_split u_split (
    .host_wdata (host_wdata),
    .host_be    (host_be),
    .even_wdata (even_wdata),
    .even_be    (even_be),
    .odd_wdata  (odd_wdata),
    .odd_be     (odd_be),
    .even_rdata (even_hq),
    .odd_rdata  (odd_hq),
    .host_word  (host_rdata)
  );

  sbr_ram_bank #(.AW(HOST_AW)) u_even (
    .clk        (clk),
    .rst        (rst),
    .we         (host_wr),
    .be         (even_be),
    .waddr      (host_addr),
    .wdata      (even_wdata),
    .host_en    (host_rd),
    .host_raddr (host_addr),
    .host_q     (even_hq),
    .snd_raddr  (snd_addr[SND_AW-1:1]),
    .snd_q      (even_sq)
  );

  sbr_ram_bank #(.AW(HOST_AW)) u_odd (
    .clk        (clk),
    .rst        (rst),
    .we         (host_wr),
    .be         (odd_be),
    .waddr      (host_addr),
    .wdata      (odd_wdata),
    .host_en    (host_rd),
    .host_raddr (host_addr),
    .host_q     (odd_hq),
    .snd_raddr  (snd_addr[SND_AW-1:1]),
    .snd_q      (odd_sq)
  );

  always_ff @(posedge clk) begin
    snd_sel_q <= snd_addr[0];
  end

  assign snd_rdata = snd_sel_q ? odd_sq : even_sq;

  sbr_run_ctrl u_run (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_be    (ctl_be),
    .halt_q    (snd_halt),
    .reset_q   (snd_reset)
  );
endmodule

// File: rtl/snd_ram_bridge_chk.sv
module snd_ram_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_rd,
  input logic [31:0] host_rdata,
  input logic        ctl_wr,
  input logic [31:0] ctl_wdata,
  input logic [3:0]  ctl_be,
  input logic        snd_halt,
  input logic        snd_reset
);
  logic upper_sel;
  assign upper_sel = ctl_wr && (ctl_be[3:2] != 2'b00);

  // R7
  run_code_chk: assert property (@(posedge clk) disable iff (rst)
    (upper_sel && ctl_wdata[31:16] == 16'h55AA) |=> (!snd_halt && !snd_reset));

  // R8
  stop_code_chk: assert property (@(posedge clk) disable iff (rst)
    (upper_sel && ctl_wdata[31:16] == 16'hAA55) |=> (snd_halt && snd_reset));

  // R9
  other_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (!upper_sel || (ctl_wdata[31:16] != 16'h55AA && ctl_wdata[31:16] != 16'hAA55))
      |=> ($stable(snd_halt) && $stable(snd_reset)));

  // R10
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (snd_halt && snd_reset));

  // R11
  pair_match_chk: assert property (@(posedge clk) disable iff (rst)
    snd_halt == snd_reset);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

bind snd_ram_bridge snd_ram_bridge_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .ctl_be     (ctl_be),
  .snd_halt   (snd_halt),
  .snd_reset  (snd_reset)
);

// File: tb/snd_ram_bridge_test.sv
`timescale 1ns/1ps
module snd_ram_bridge_test;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [3:0]    host_be = '0;
  logic [31:0]   host_rdata;
  logic [AW:0]   snd_addr = '0;
  logic [15:0]   snd_rdata;
  logic          ctl_wr = 1'b0;
  logic [31:0]   ctl_wdata = '0;
  logic [3:0]    ctl_be = '0;
  logic          snd_halt, snd_reset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  snd_ram_bridge #(.HOST_AW(AW)) uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_be(host_be),
    .host_rdata(host_rdata), .snd_addr(snd_addr), .snd_rdata(snd_rdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_be(ctl_be),
    .snd_halt(snd_halt), .snd_reset(snd_reset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_be = be; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_be = 4'h0;
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic snd_read(input logic [AW:0] a, output logic [15:0] d);
    @(negedge clk);
    snd_addr = a;
    @(negedge clk);
    d = snd_rdata;
  endtask

  task automatic ctl_write(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    ctl_wdata = d; ctl_be = be; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_be = 4'h0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 halt after reset", {31'd0, snd_halt}, 32'd1);
    check("R10 reset after reset", {31'd0, snd_reset}, 32'd1);
    check("R10 rdata after reset", host_rdata, 32'h0);
  endtask

  task automatic t_full_word;
    logic [15:0] s;
    logic [31:0] h;
    host_write(4'd3, 32'h1122_3344, 4'hF);
    snd_read(5'd6, s);
    check("R1 R2 location 2N", {16'd0, s}, 32'h0000_2211);
    snd_read(5'd7, s);
    check("R1 R2 location 2N+1", {16'd0, s}, 32'h0000_4433);
    host_read(4'd3, h);
    check("R4 full readback", h, 32'h1122_3344);
  endtask

  task automatic t_partial;
    logic [15:0] s;
    logic [31:0] h;
    host_write(4'd3, 32'hAABB_CCDD, 4'b0100);
    snd_read(5'd6, s);
    check("R3 lane2 into 2N high byte", {16'd0, s}, 32'h0000_BB11);
    snd_read(5'd7, s);
    check("R3 2N+1 untouched", {16'd0, s}, 32'h0000_4433);
    host_write(4'd3, 32'h0000_00EE, 4'b0001);
    host_read(4'd3, h);
    check("R3 R4 two partial writes", h, 32'h11BB_33EE);
  endtask

  task automatic t_edges;
    logic [15:0] s;
    logic [31:0] h;
    host_write(4'd15, 32'hDEAD_BEEF, 4'hF);
    host_write(4'd0, 32'h0102_0304, 4'hF);
    snd_read(5'd30, s);
    check("R6 top even location", {16'd0, s}, 32'h0000_ADDE);
    snd_read(5'd31, s);
    check("R6 top odd location", {16'd0, s}, 32'h0000_EFBE);
    snd_read(5'd0, s);
    check("R6 bottom even location", {16'd0, s}, 32'h0000_0201);
    host_read(4'd15, h);
    check("R4 top offset readback", h, 32'hDEAD_BEEF);
    host_read(4'd0, h);
    check("R4 bottom offset readback", h, 32'h0102_0304);
  endtask

  task automatic t_hold;
    logic [31:0] h;
    host_read(4'd15, h);
    host_write(4'd15, 32'h5555_6666, 4'hF);
    @(negedge clk);
    host_addr = 4'd3;
    repeat (3) @(negedge clk);
    check("R5 rdata held without strobe", host_rdata, 32'hDEAD_BEEF);
    host_read(4'd15, h);
    check("R4 read after hold", h, 32'h5555_6666);
  endtask

  task automatic t_ctl;
    ctl_write(32'h55AA_0000, 4'b1100);
    check("R7 halt released", {31'd0, snd_halt}, 32'd0);
    check("R11 reset follows", {31'd0, snd_reset}, 32'd0);
    ctl_write(32'h1234_0000, 4'b1100);
    check("R9 other code ignored", {30'd0, snd_halt, snd_reset}, 32'd0);
    ctl_write(32'hAA55_AA55, 4'b0011);
    check("R9 lower-only ignored", {30'd0, snd_halt, snd_reset}, 32'd0);
    ctl_write(32'hAA55_0000, 4'b1000);
    check("R8 stop asserts both", {30'd0, snd_halt, snd_reset}, 32'd3);
    ctl_write(32'h55AA_FFFF, 4'b0011);
    check("R9 lower-only ignored while stopped", {30'd0, snd_halt, snd_reset}, 32'd3);
    ctl_write(32'h55AA_0000, 4'b0100);
    check("R7 single upper enable releases", {30'd0, snd_halt, snd_reset}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_reset;
    t_full_word;
    t_partial;
    t_edges;
    t_hold;
    t_ctl;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule